// File: doc/BRIEF.md
# Paged Address Window Translator

This block turns 32-bit addresses that fall inside a linear aperture window into 64-bit physical addresses. The window is cut into 4 KB pages, and each page may land anywhere in physical memory. The upper address bits name a page. The page selects an 8-byte page-table entry held in a local SRAM. The entry gives the physical page frame and a valid flag. The low 12 address bits pass through unchanged as the offset within the page.

Software fills the table through an indexed pair of registers: first a byte offset, then a data word. A group register carries the table base, an enable and two attribute bits. A page-size register must hold the 4 KB code before any translation succeeds. Four translations are kept in a small fully associative cache with round-robin replacement. A repeated page is therefore answered at once, and a cache miss walks the table in SRAM. The cache does not track later writes to the table. Software must issue an invalidate command after it edits the table and before it starts traffic that relies on the new entries.

Top module: `pwin_xlate_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid` is 0. The group enable is 0 and the page-size code is 0, so every lookup answers with a fault.
- R2: A configuration write with `cfg_sel`=0 loads the byte-offset index. A write with `cfg_sel`=1 stores `cfg_wdata` into the SRAM word at index bits [RAM_AW+1:2].
- R3: The entry for page p (p = `req_addr`[31:12]) sits at byte `table base + p*8`. The low word is at +0 and the high word at +4. A valid entry answers with `resp_paddr` = {1'b0, high[30:0], low[31:12], `req_addr`[11:0]}.
- R4: Bit 31 of the high word is the valid flag. When it is clear, the answer is a fault: `resp_fault`=1, `resp_paddr`=0 and both attribute outputs 0. A faulting entry is never cached, so setting its flag later takes effect without an invalidate.
- R5: The group register is written with `cfg_sel`=2, and bit 0 is the group enable. The page-size register is written with `cfg_sel`=3. If the group enable is 0, or the page-size code is not 4'h2, the lookup faults. That fault is answered on the accepting edge.
- R6: A page number of NUM_PTE or above faults on the accepting edge, without a table read.
- R7: On a cache miss, the answer appears on the third clock edge after the accepting edge. `req_ready` stays 0 from the accepting edge until the answer arrives.
- R8: On a cache hit, the answer appears on the accepting edge. It returns the cached translation, even if the table word was rewritten afterwards.
- R9: A write with `cfg_sel`=4 and `cfg_wdata`[0]=1 drops every cached translation. The same write with bit 0 clear has no effect.
- R10: Valid entries fill the cache slots in round-robin order, and the order starts again from slot 0 after an invalidate. The fifth distinct page evicts the first one filled.
- R11: On a successful answer, `resp_snoop` equals group bit 1 and `resp_sysmem` equals group bit 2.
- R12: Group bits [RAM_AW+1:12] set the table base in 4 KB units. The reset value is byte offset 0x1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 index, 1 data, 2 group, 3 page size, 4 invalidate |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Aperture address to translate |
| req_ready | output | 1 | Block can accept a lookup |
| resp_valid | output | 1 | One-cycle answer strobe |
| resp_fault | output | 1 | Answer is a fault |
| resp_paddr | output | 64 | Translated physical address |
| resp_snoop | output | 1 | Snoop attribute of the answer |
| resp_sysmem | output | 1 | Target-memory attribute of the answer |

## Verification
The bench builds the block with its defaults: a 2048-word SRAM, 256 table entries and 4 cache slots. With these values the last legal page (255) and the first illegal page (256) can both be reached in a short run. Four slots can be filled and then overrun within a handful of lookups, which exercises the round-robin wrap and an eviction. The 8 KB SRAM holds both a table at base 0x1000 and one moved to base 0, so a base change can be shown to redirect the table walk.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  localparam int PG_SHIFT  = 12;
  localparam int VA_W      = 32;
  localparam int VPN_W     = VA_W - PG_SHIFT;
  localparam int PFN_W     = 63 - PG_SHIFT;
  localparam int PTE_VLD   = 31;
  localparam logic [3:0] PSZ_4K = 4'h2;
  localparam int GRP_EN    = 0;
  localparam int GRP_SNOOP = 1;
  localparam int GRP_SYS   = 2;

  typedef enum logic [2:0] {
    SEL_IDX   = 3'd0,
    SEL_DATA  = 3'd1,
    SEL_GRP   = 3'd2,
    SEL_PSZ   = 3'd3,
    SEL_INVAL = 3'd4
  } cfg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_LO = 2'd1,
    ST_RD_HI = 2'd2,
    ST_FILL  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/pwin_cfg_regs.sv
module pwin_cfg_regs
  import pwin_pkg::*;
#(
  parameter int RAM_BAW = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_sel,
  input  logic [31:0]        cfg_wdata,
  output logic               ram_we,
  output logic [RAM_BAW-3:0] ram_waddr,
  output logic [31:0]        ram_wdata,
  output logic               tc_inval,
  output logic               xlat_en,
  output logic               grp_snoop,
  output logic               grp_sysmem,
  output logic [RAM_BAW-1:0] tbl_base
);
  localparam int BASE_W = RAM_BAW - PG_SHIFT;
  localparam logic [BASE_W-1:0] BASE_RST = BASE_W'(1);

  logic [RAM_BAW-1:0] idx_q;
  logic [BASE_W-1:0]  base_q;
  logic               en_q, snoop_q, sys_q;
  logic [3:0]         psz_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      base_q  <= BASE_RST;
      en_q    <= 1'b0;
      snoop_q <= 1'b0;
      sys_q   <= 1'b0;
      psz_q   <= 4'h0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_IDX: idx_q <= cfg_wdata[RAM_BAW-1:0];
        SEL_GRP: begin
          base_q  <= cfg_wdata[RAM_BAW-1:PG_SHIFT];
          en_q    <= cfg_wdata[GRP_EN];
          snoop_q <= cfg_wdata[GRP_SNOOP];
          sys_q   <= cfg_wdata[GRP_SYS];
        end
        SEL_PSZ: psz_q <= cfg_wdata[3:0];
        default: ;
      endcase
    end
  end

  assign ram_we     = cfg_we && (cfg_sel == SEL_DATA);
  assign ram_waddr  = idx_q[RAM_BAW-1:2];
  assign ram_wdata  = cfg_wdata;
  assign tc_inval   = cfg_we && (cfg_sel == SEL_INVAL) && cfg_wdata[0];
  assign xlat_en    = en_q && (psz_q == PSZ_4K);
  assign grp_snoop  = snoop_q;
  assign grp_sysmem = sys_q;
  assign tbl_base   = {base_q, {PG_SHIFT{1'b0}}};
endmodule

// File: rtl/pwin_pte_ram.sv
module pwin_pte_ram #(
  parameter int AW = 11,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pwin_tcache.sv
module pwin_tcache #(
  parameter int N     = 4,
  parameter int TAG_W = 8,
  parameter int DAT_W = 51
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [N-1:0]     hit_vec,
  output logic [DAT_W-1:0] lk_data,
  input  logic             fill_en,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [DAT_W-1:0] fill_data,
  input  logic             inval
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  logic [N-1:0]     vld_q;
  logic [TAG_W-1:0] tag_q [N];
  logic [DAT_W-1:0] dat_q [N];
  logic [PW-1:0]    ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (inval) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else if (fill_en) begin
      for (int i = 0; i < N; i++) begin
        if (ptr_q == PW'(i)) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= fill_tag;
          dat_q[i] <= fill_data;
        end
      end
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    lk_data = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) lk_data = lk_data | dat_q[i];
  end
endmodule

// File: rtl/pwin_xlate_top.sv
module pwin_xlate_top
  import pwin_pkg::*;
#(
  parameter int RAM_AW     = 11,
  parameter int NUM_PTE    = 256,
  parameter int TC_ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        req_ready,
  output logic        resp_valid,
  output logic        resp_fault,
  output logic [63:0] resp_paddr,
  output logic        resp_snoop,
  output logic        resp_sysmem
);
  localparam int RAM_BAW = RAM_AW + 2;
  localparam int PTE_AW  = $clog2(NUM_PTE);
  localparam int PAD_W   = RAM_BAW - PTE_AW - 3;
  localparam logic [VPN_W-1:0] VPN_LIMIT = VPN_W'(NUM_PTE);

  logic               ram_we;
  logic [RAM_AW-1:0]  ram_waddr, ram_raddr;
  logic [31:0]        ram_wdata, ram_rdata;
  logic               tc_inval, xlat_en, grp_snoop, grp_sysmem;
  logic [RAM_BAW-1:0] tbl_base;

  pwin_cfg_regs #(.RAM_BAW(RAM_BAW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .tc_inval(tc_inval), .xlat_en(xlat_en), .grp_snoop(grp_snoop),
    .grp_sysmem(grp_sysmem), .tbl_base(tbl_base)
  );

  pwin_pte_ram #(.AW(RAM_AW), .DW(32)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  walk_st_e              st_q;
  logic [PTE_AW-1:0]     idx_q;
  logic [PG_SHIFT-1:0]   off_q;
  logic [31:PG_SHIFT]    lo_q;

  logic [VPN_W-1:0]      vpn;
  logic [PG_SHIFT-1:0]   off;
  logic                  in_range;
  logic [TC_ENTRIES-1:0] tc_hit_vec;
  logic                  tc_hit;
  logic [PFN_W-1:0]      tc_data;
  logic                  fill_en;
  logic [RAM_BAW-1:0]    ent_byte;
  logic [RAM_AW-1:0]     lo_waddr, hi_waddr;

  assign vpn      = req_addr[VA_W-1:PG_SHIFT];
  assign off      = req_addr[PG_SHIFT-1:0];
  assign in_range = vpn < VPN_LIMIT;
  assign tc_hit   = |tc_hit_vec;
  assign fill_en  = (st_q == ST_FILL) && ram_rdata[PTE_VLD];

  pwin_tcache #(.N(TC_ENTRIES), .TAG_W(PTE_AW), .DAT_W(PFN_W)) u_tc (
    .clk(clk), .rst(rst), .lk_tag(vpn[PTE_AW-1:0]), .hit_vec(tc_hit_vec),
    .lk_data(tc_data), .fill_en(fill_en), .fill_tag(idx_q),
    .fill_data({ram_rdata[30:0], lo_q}), .inval(tc_inval)
  );

  assign ent_byte  = tbl_base + {{PAD_W{1'b0}}, idx_q, 3'b000};
  assign lo_waddr  = ent_byte[RAM_BAW-1:2];
  assign hi_waddr  = {lo_waddr[RAM_AW-1:1], 1'b1};
  assign ram_raddr = (st_q == ST_RD_HI) ? hi_waddr : lo_waddr;
  assign req_ready = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      idx_q       <= '0;
      off_q       <= '0;
      lo_q        <= '0;
      resp_valid  <= 1'b0;
      resp_fault  <= 1'b0;
      resp_paddr  <= '0;
      resp_snoop  <= 1'b0;
      resp_sysmem <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (!xlat_en || !in_range) begin
              resp_valid  <= 1'b1;
              resp_fault  <= 1'b1;
              resp_paddr  <= '0;
              resp_snoop  <= 1'b0;
              resp_sysmem <= 1'b0;
            end else if (tc_hit) begin
              resp_valid  <= 1'b1;
              resp_fault  <= 1'b0;
              resp_paddr  <= {1'b0, tc_data, off};
              resp_snoop  <= grp_snoop;
              resp_sysmem <= grp_sysmem;
            end else begin
              idx_q <= vpn[PTE_AW-1:0];
              off_q <= off;
              st_q  <= ST_RD_LO;
            end
          end
        end
        ST_RD_LO: st_q <= ST_RD_HI;
        ST_RD_HI: begin
          lo_q <= ram_rdata[31:PG_SHIFT];
          st_q <= ST_FILL;
        end
        default: begin
          resp_valid <= 1'b1;
          if (ram_rdata[PTE_VLD]) begin
            resp_fault  <= 1'b0;
            resp_paddr  <= {1'b0, ram_rdata[30:0], lo_q, off_q};
            resp_snoop  <= grp_snoop;
            resp_sysmem <= grp_sysmem;
          end else begin
            resp_fault  <= 1'b1;
            resp_paddr  <= '0;
            resp_snoop  <= 1'b0;
            resp_sysmem <= 1'b0;
          end
          st_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pwin_xlate_chk.sv
module pwin_xlate_chk #(
  parameter int N = 4
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        resp_valid,
  input logic        resp_fault,
  input logic [63:0] resp_paddr,
  input logic        resp_snoop,
  input logic        resp_sysmem,
  input logic [N-1:0] hit_vec,
  input logic        xlat_en
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !resp_valid));

  p_fault_clean_r4: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_fault) |-> (resp_paddr == 64'd0 && !resp_snoop && !resp_sysmem));

  p_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_fault && $past(req_valid && req_ready)) |-> $past(xlat_en));

  p_busy_silent_r7: assert property (@(posedge clk) disable iff (rst)
    !req_ready |-> !resp_valid);

  p_done_answers_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> resp_valid);

  p_hit_unique_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
endmodule

bind pwin_xlate_top pwin_xlate_chk #(.N(TC_ENTRIES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
  .resp_snoop(resp_snoop), .resp_sysmem(resp_sysmem),
  .hit_vec(tc_hit_vec), .xlat_en(xlat_en)
);

// File: tb/tb_pwin_xlate_top.sv
module tb_pwin_xlate_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = 3'd0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = 32'd0;
  logic        req_ready, resp_valid, resp_fault, resp_snoop, resp_sysmem;
  logic [63:0] resp_paddr;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic        r_fault, r_sn, r_sm, r_busy_ok;
  logic [63:0] r_pa;
  int          r_lat;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwin_xlate_top dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
    .resp_snoop(resp_snoop), .resp_sysmem(resp_sysmem)
  );

  // vector table: address, expected fault, expected address, expected latency
  localparam logic [31:0] V_ADDR [NV] = '{32'h0000_0ABC, 32'h0000_0123, 32'h0000_1FFF,
    32'h0000_2000, 32'h0000_3010, 32'h0000_3010, 32'h000F_F7FF, 32'h0010_0000,
    32'hFFFF_F000, 32'h0000_1004};
  localparam logic V_FAULT [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [63:0] V_PA [NV] = '{64'h0000_0001_1234_5ABC, 64'h0000_0001_1234_5123,
    64'h0000_0000_ABCD_EFFF, 64'h7FFF_FFFF_0000_1000, 64'd0, 64'd0,
    64'h0000_0010_0F00_07FF, 64'd0, 64'd0, 64'h0000_0000_ABCD_E004};
  localparam int V_LAT [NV] = '{3, 0, 3, 3, 3, 3, 3, 0, 0, 0};
  localparam string V_TAG [NV] = '{"R3", "R8", "R3", "R3", "R4", "R4", "R3", "R6", "R6", "R8"};

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_pte(input logic [31:0] base, input int pg, input logic [31:0] lo, input logic [31:0] hi);
    cfg_write(3'd0, base + 32'(pg) * 8);
    cfg_write(3'd1, lo);
    cfg_write(3'd0, base + 32'(pg) * 8 + 4);
    cfg_write(3'd1, hi);
  endtask

  task automatic lookup(input logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 0; r_busy_ok = 1'b1;
    while (!resp_valid && r_lat < 8) begin
      if (req_ready) r_busy_ok = 1'b0;
      @(negedge clk);
      r_lat++;
    end
    r_fault = resp_fault; r_pa = resp_paddr; r_sn = resp_snoop; r_sm = resp_sysmem;
  endtask

  task automatic expect_xl(input string tag, input logic [31:0] a, input logic f,
                           input logic [63:0] pa, input int lat);
    lookup(a);
    chk(r_fault == f, {tag, " fault"}, 64'(r_fault), 64'(f));
    chk(r_pa == pa, {tag, " paddr"}, r_pa, pa);
    chk(r_lat == lat, {tag, (lat == 3) ? " R7 latency" : " latency"}, 64'(r_lat), 64'(lat));
    if (lat > 0) chk(r_busy_ok, {tag, " R7 ready low"}, 64'(r_busy_ok), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset, lookups fault until enabled
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(resp_valid == 1'b0, "R1 resp_valid", 64'(resp_valid), 64'd0);
    expect_xl("R1", 32'h0000_0ABC, 1'b1, 64'd0, 0);

    // R2: table through indexed pair at base 0x1000
    put_pte(32'h1000, 0,   32'h1234_5000, 32'h8000_0001);
    put_pte(32'h1000, 1,   32'hABCD_E000, 32'h8000_0000);
    put_pte(32'h1000, 2,   32'h0000_1FFF, 32'hFFFF_FFFF);
    put_pte(32'h1000, 3,   32'h5555_5000, 32'h0000_0005);
    put_pte(32'h1000, 255, 32'h0F00_0000, 32'h8000_0010);
    put_pte(32'h1000, 4,   32'h4444_4000, 32'h8000_0000);
    cfg_write(3'd3, 32'h2);
    cfg_write(3'd2, 32'h0000_1003);

    for (int i = 0; i < NV; i++) begin
      expect_xl(V_TAG[i], V_ADDR[i], V_FAULT[i], V_PA[i], V_LAT[i]);
      chk(r_sn == !V_FAULT[i], "R11 snoop", 64'(r_sn), 64'(!V_FAULT[i]));
      chk(r_sm == 1'b0, "R11 sysmem", 64'(r_sm), 64'd0);
    end

    // R8: stale cached value after table rewrite
    put_pte(32'h1000, 1, 32'h1111_1000, 32'h8000_0000);
    expect_xl("R8 stale", 32'h0000_1010, 1'b0, 64'h0000_0000_ABCD_E010, 0);
    // R9: invalidate with bit0 clear has no effect, with bit0 set drops all
    cfg_write(3'd4, 32'h2);
    expect_xl("R9 no-op", 32'h0000_1010, 1'b0, 64'h0000_0000_ABCD_E010, 0);
    cfg_write(3'd4, 32'h1);
    expect_xl("R9 refetch", 32'h0000_1010, 1'b0, 64'h0000_0000_1111_1010, 3);

    // R10: round robin, p1 slot0, then p0,p2,p255 fill 1..3, p4 evicts p1
    expect_xl("R10 fill", 32'h0000_0000, 1'b0, 64'h0000_0001_1234_5000, 3);
    expect_xl("R10 fill", 32'h0000_2000, 1'b0, 64'h7FFF_FFFF_0000_1000, 3);
    expect_xl("R10 fill", 32'h000F_F000, 1'b0, 64'h0000_0010_0F00_0000, 3);
    expect_xl("R10 fill", 32'h0000_4000, 1'b0, 64'h0000_0000_4444_4000, 3);
    expect_xl("R10 kept", 32'h0000_0008, 1'b0, 64'h0000_0001_1234_5008, 0);
    expect_xl("R10 evicted", 32'h0000_1020, 1'b0, 64'h0000_0000_1111_1020, 3);

    // R4: fault was not cached, setting the flag takes effect
    put_pte(32'h1000, 3, 32'h5555_5000, 32'h8000_0005);
    expect_xl("R4 uncached", 32'h0000_3010, 1'b0, 64'h0000_0005_5555_5010, 3);

    // R5: page-size code and group enable gate translation
    cfg_write(3'd3, 32'h1);
    expect_xl("R5 psize", 32'h0000_4008, 1'b1, 64'd0, 0);
    cfg_write(3'd3, 32'h2);
    cfg_write(3'd2, 32'h0000_1000);
    expect_xl("R5 enable", 32'h0000_4008, 1'b1, 64'd0, 0);
    cfg_write(3'd2, 32'h0000_1005);
    expect_xl("R5 on", 32'h0000_4008, 1'b0, 64'h0000_0000_4444_4008, 0);
    chk(r_sn == 1'b0, "R11 snoop off", 64'(r_sn), 64'd0);
    chk(r_sm == 1'b1, "R11 sysmem on", 64'(r_sm), 64'd1);

    // R12: move table base to 0
    cfg_write(3'd2, 32'h0000_0005);
    cfg_write(3'd4, 32'h1);
    put_pte(32'h0, 6, 32'h6666_6000, 32'h8000_0000);
    expect_xl("R12 base0", 32'h0000_6ABC, 1'b0, 64'h0000_0000_6666_6ABC, 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule